// File: doc/BRIEF.md
# I2C EEPROM Target Engine

This block is the bus-facing half of a serial memory. It watches SCL and SDA through synchronizers clocked by a fast system clock, finds START and STOP conditions, and takes in the device select byte. It answers only when the select byte carries the memory type code and the three chip-enable strap inputs.

Once selected for a write, the engine takes a 16-bit address, high byte first, into its internal pointer. Every byte after that goes to a separate write controller over a valid/ready channel, and a STOP tells that controller to start its internal write cycle. Once selected for a read, the engine fetches bytes from a memory port and shifts them out MSB first. The pointer advances after each byte sent, so current-address, random and sequential reads all follow from the same counter. SDA is driven as an open-drain enable. While the write controller reports a write cycle in progress, the engine ignores START.

Back-pressure rules:
- The read request channel (`rd_req_*`) keeps valid and the address stable until ready is high at a clock edge.
- The read response (`rd_rsp_*`) has no ready signal. The engine always takes it. It must arrive before the SCL falling edge that follows the acknowledge clock, because that edge puts the first data bit on the bus.
- The write channel (`wr_*`) keeps valid, address and data stable until ready. If a new byte completes while the previous one is still waiting, the new byte is not acknowledged and is dropped.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, `sda_oe_o`, `rd_req_valid_o`, `wr_valid_o` and `wr_commit_o` are all 0, and the engine is in standby.
- R2: A START is a falling edge of SDA while SCL is high, and it restarts select-byte reception from any state, which includes a repeated START in the middle of a transfer. A STOP is a rising edge of SDA while SCL is high, and it returns the engine to standby.
- R3: The select byte is sampled MSB first on SCL rising edges. Bits 7:4 must be 1010 and bits 3:1 must equal `ce_strap_i[2:0]`, in the same bit order. Bit 0 is the direction: 1 for read, 0 for write. The engine acknowledges by asserting `sda_oe_o` during the 9th clock only when the select byte matches.
- R4: A select byte that does not match sends the engine to standby. It then acknowledges no further byte until the next START.
- R5: `sda_oe_o` changes only on the system clock cycle right after a detected SCL falling edge, so it is stable while SCL is high.
- R6: After a write select, the next two bytes are the address, high byte first. Each is acknowledged, and together they load the 16-bit pointer.
- R7: Each later write byte is acknowledged and appears on `wr_data_o` with `wr_addr_o` equal to the pointer. The pointer then increments.
- R8: `wr_valid_o` holds with stable address and data until `wr_ready_i`. A byte that completes while the previous one is still waiting is not acknowledged, is dropped, and leaves the pointer unchanged.
- R9: A STOP that ends a transfer with at least one accepted write byte produces a one-cycle pulse on `wr_commit_o`. A transfer with no accepted write byte produces none.
- R10: A read select fetches the byte at the pointer through the read request channel. Data goes out MSB first. The pointer increments after each byte sent and wraps from FFFF to 0000. The request holds until ready.
- R11: A sequential read continues while the master acknowledges. A NoAck sends the engine to standby. A later current-address read starts at the pointer, one past the last byte sent.
- R12: A random read works as a write select plus two address bytes, then a repeated START and a read select. The first byte read comes from the new address.
- R13: While `write_busy_i` is high, a START is ignored and the engine keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ce_strap_i | input | 3 | Chip-enable strap value |
| write_busy_i | input | 1 | Internal write cycle in progress |
| rd_req_valid_o | output | 1 | Read fetch request valid |
| rd_req_ready_i | input | 1 | Memory accepts the fetch request |
| rd_req_addr_o | output | AW | Address to fetch |
| rd_rsp_valid_i | input | 1 | Fetched byte valid |
| rd_rsp_data_i | input | 8 | Fetched byte |
| wr_valid_o | output | 1 | Write byte valid |
| wr_ready_i | input | 1 | Write controller accepts the byte |
| wr_addr_o | output | AW | Address for the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the internal write cycle |

## Verification
Some properties are checked on every cycle:
- `sda_oe_o` changes only right after a detected SCL fall.
- Both outgoing channels hold valid, address and data until accepted.
- The commit output is a single-cycle pulse.
- A START seen while the write cycle is busy leaves the state unchanged.
- The engine never starts driving SDA while it is in standby.

Other behaviour only the bus scenarios can show:
- Whether the right bytes are acknowledged.
- Whether select decoding honours the straps.
- Whether the pointer sequence stays correct across writes, discarded writes, wraparound, repeated START and current-address reads.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  // Transfer phase of the protocol engine
  typedef enum logic [2:0] {
    ST_IDLE,   // standby, waiting for START
    ST_DEV,    // receiving select byte
    ST_AHI,    // receiving address high byte
    ST_ALO,    // receiving address low byte
    ST_WR,     // receiving write data
    ST_RD      // transmitting read data
  } xfer_st_e;

  localparam int          CE_W       = 3;
  localparam logic [3:0]  TYPE_CODE  = 4'b1010;
  localparam logic [3:0]  LAST_BIT   = 4'd7;
  localparam logic [3:0]  ACK_SLOT   = 4'd8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_lvl;

  // Idle bus is high on both lines, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl    = scl_pipe[STAGES-1];
  assign sda_lvl    = sda_pipe[STAGES-1];
  assign scl_rise   = scl_lvl & ~scl_q;
  assign scl_fall   = ~scl_lvl & scl_q;
  // SCL high on both samples while SDA moves
  assign start_seen = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_seen  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic          inc,
  input  logic [7:0]    din,
  output logic [AW-1:0] ptr
);

  localparam int HI_W = AW - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_hi) begin
      ptr[AW-1:8] <= din[HI_W-1:0];
    end else if (load_lo) begin
      ptr[7:0] <= din;
    end else if (inc) begin
      ptr <= ptr + AW'(1);
    end
  end

endmodule

// File: rtl/eeprom_xfer_fsm.sv
module eeprom_xfer_fsm
  import eeprom_i2c_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_lvl,
  input  logic            start_seen,
  input  logic            stop_seen,
  input  logic [CE_W-1:0] ce_strap_i,
  input  logic            write_busy_i,
  input  logic [AW-1:0]   ptr,
  output logic            ptr_load_hi,
  output logic            ptr_load_lo,
  output logic            ptr_inc,
  output logic [7:0]      rx_byte,
  output logic            sda_oe,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  input  logic            rd_rsp_valid,
  input  logic [7:0]      rd_rsp_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [7:0]      wr_data,
  output logic            wr_commit,
  output xfer_st_e        state
);

  logic [3:0] bit_cnt;
  logic [7:0] rx_sr;
  logic [7:0] tx_sr;
  logic       ack_pend;
  logic       rw_q;
  logic       wr_seen;

  logic       start_ok;
  logic       byte_done;
  logic       sel_match;
  logic       wr_ok;
  logic       wr_take;
  logic       rd_next;
  logic       rd_first;

  assign rx_byte   = {rx_sr[6:0], sda_lvl};
  assign start_ok  = start_seen & ~write_busy_i;
  assign byte_done = scl_rise && (bit_cnt == LAST_BIT) &&
                     (state inside {ST_DEV, ST_AHI, ST_ALO, ST_WR});
  assign sel_match = (rx_byte[7:4] == TYPE_CODE) && (rx_byte[3:1] == ce_strap_i);
  assign wr_ok     = ~(wr_valid & ~wr_ready);
  assign wr_take   = byte_done && (state == ST_WR) && wr_ok;
  assign rd_first  = byte_done && (state == ST_DEV) && sel_match && rx_byte[0];
  assign rd_next   = scl_rise && (state == ST_RD) && (bit_cnt == LAST_BIT);

  assign ptr_load_hi = byte_done && (state == ST_AHI);
  assign ptr_load_lo = byte_done && (state == ST_ALO);
  assign ptr_inc     = wr_take | rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sr        <= '0;
      tx_sr        <= '1;
      ack_pend     <= 1'b0;
      rw_q         <= 1'b0;
      wr_seen      <= 1'b0;
      sda_oe       <= 1'b0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      wr_commit    <= 1'b0;
    end else begin
      // outgoing channel handshakes
      if (rd_req_valid && rd_req_ready) rd_req_valid <= 1'b0;
      if (rd_first || rd_next) begin
        rd_req_valid <= 1'b1;
        rd_req_addr  <= rd_next ? ptr + AW'(1) : ptr;
      end
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (wr_take) begin
        wr_valid <= 1'b1;
        wr_addr  <= ptr;
        wr_data  <= rx_byte;
      end

      wr_commit <= 1'b0;

      // protocol sequencing
      if (start_ok) begin
        state    <= ST_DEV;
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
      end else if (stop_seen) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        ack_pend  <= 1'b0;
        wr_commit <= wr_seen;
        wr_seen   <= 1'b0;
      end else if (scl_rise && state != ST_IDLE) begin
        if (bit_cnt != ACK_SLOT) begin
          bit_cnt <= bit_cnt + 4'd1;
          rx_sr   <= rx_byte;
          if (bit_cnt == LAST_BIT) begin
            unique case (state)
              ST_DEV: begin
                if (sel_match) begin
                  ack_pend <= 1'b1;
                  rw_q     <= rx_byte[0];
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI, ST_ALO: ack_pend <= 1'b1;
              ST_WR: begin
                ack_pend <= wr_ok;
                if (wr_ok) wr_seen <= 1'b1;
              end
              default: ack_pend <= 1'b0;
            endcase
          end
        end else begin
          // ninth clock: acknowledge slot
          bit_cnt  <= '0;
          ack_pend <= 1'b0;
          unique case (state)
            ST_DEV:  state <= rw_q ? ST_RD : ST_AHI;
            ST_AHI:  state <= ST_ALO;
            ST_ALO:  state <= ST_WR;
            ST_RD:   if (sda_lvl) state <= ST_IDLE;
            default: state <= state;
          endcase
        end
      end

      // SDA drive, updated only after SCL falls
      if (scl_fall) begin
        if (state == ST_IDLE) begin
          sda_oe <= 1'b0;
        end else if (state == ST_RD) begin
          if (bit_cnt == ACK_SLOT) begin
            sda_oe <= 1'b0;
          end else begin
            sda_oe <= ~tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b1};
          end
        end else begin
          sda_oe <= (bit_cnt == ACK_SLOT) && ack_pend;
        end
      end

      if (rd_rsp_valid) tx_sr <= rd_rsp_data;
    end
  end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [CE_W-1:0] ce_strap_i,
  input  logic            write_busy_i,
  output logic            rd_req_valid_o,
  input  logic            rd_req_ready_i,
  output logic [AW-1:0]   rd_req_addr_o,
  input  logic            rd_rsp_valid_i,
  input  logic [7:0]      rd_rsp_data_i,
  output logic            wr_valid_o,
  input  logic            wr_ready_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [7:0]      wr_data_o,
  output logic            wr_commit_o
);

  logic          sda_lvl;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_seen;
  logic          stop_seen;
  logic          ptr_load_hi;
  logic          ptr_load_lo;
  logic          ptr_inc;
  logic [7:0]    rx_byte;
  logic [AW-1:0] ptr;
  xfer_st_e      xfer_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  eeprom_addr_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hi (ptr_load_hi),
    .load_lo (ptr_load_lo),
    .inc     (ptr_inc),
    .din     (rx_byte),
    .ptr     (ptr)
  );

  eeprom_xfer_fsm #(.AW(AW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_lvl      (sda_lvl),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .ce_strap_i   (ce_strap_i),
    .write_busy_i (write_busy_i),
    .ptr          (ptr),
    .ptr_load_hi  (ptr_load_hi),
    .ptr_load_lo  (ptr_load_lo),
    .ptr_inc      (ptr_inc),
    .rx_byte      (rx_byte),
    .sda_oe       (sda_oe_o),
    .rd_req_valid (rd_req_valid_o),
    .rd_req_ready (rd_req_ready_i),
    .rd_req_addr  (rd_req_addr_o),
    .rd_rsp_valid (rd_rsp_valid_i),
    .rd_rsp_data  (rd_rsp_data_i),
    .wr_valid     (wr_valid_o),
    .wr_ready     (wr_ready_i),
    .wr_addr      (wr_addr_o),
    .wr_data      (wr_data_o),
    .wr_commit    (wr_commit_o),
    .state        (xfer_state)
  );

endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_fall,
  input logic          start_seen,
  input logic          write_busy_i,
  input xfer_st_e      state,
  input logic          sda_oe,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_commit
);

  // R5
  oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(state) != ST_IDLE);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R9
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_busy_i && start_seen |=> $stable(state));

endmodule

bind eeprom_i2c_target eeprom_i2c_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_fall     (scl_fall),
  .start_seen   (start_seen),
  .write_busy_i (write_busy_i),
  .state        (xfer_state),
  .sda_oe       (sda_oe_o),
  .rd_valid     (rd_req_valid_o),
  .rd_ready     (rd_req_ready_i),
  .rd_addr      (rd_req_addr_o),
  .wr_valid     (wr_valid_o),
  .wr_ready     (wr_ready_i),
  .wr_addr      (wr_addr_o),
  .wr_data      (wr_data_o),
  .wr_commit    (wr_commit_o)
);

// File: tb/tb_eeprom_i2c_target.sv
module tb_eeprom_i2c_target;

  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 8;
  localparam logic [2:0] STRAP      = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        write_busy = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_commit;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int commits = 0;
  bit done = 1'b0;
  logic [23:0] wr_exp[$];
  logic [7:0]  rd_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .ce_strap_i(STRAP), .write_busy_i(write_busy),
    .rd_req_valid_o(rd_valid), .rd_req_ready_i(rd_ready), .rd_req_addr_o(rd_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] t;
    t = 8'(a[7:0] * 8'd3);
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b;    wt(HALF);
    scl_m = 1'b1; wt(HALF);
    scl_m = 1'b0; wt(2);
  endtask

  // R5: the enable must not move while SCL is high
  task automatic bit_in(output logic b);
    logic oa, ob;
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(2);
    oa = sda_oe;  wt(HALF/2 - 2);
    b = sda_line; wt(HALF/2);
    ob = sda_oe;
    chk(oa == ob, "R5", ob, oa);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic send_expect(input logic [7:0] v, input bit exp_ack, input string req);
    bit a;
    send_byte(v, a);
    chk(a == exp_ack, req, a, exp_ack);
  endtask

  // driver pushes expectations, read path pops and compares
  task automatic read_seq(input logic [15:0] first, input int n, input string req);
    logic [7:0] d, e;
    logic b;
    for (int i = 0; i < n; i++) rd_exp.push_back(memf(first + 16'(i)));
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) begin
        bit_in(b);
        d[k] = b;
      end
      bit_out((i == n - 1) ? 1'b1 : 1'b0);
      e = rd_exp.pop_front();
      chk(d == e, req, d, e);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // memory responder: accept request, answer two cycles later
  initial begin
    logic [15:0] a;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        a = rd_addr;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        @(negedge clk);
        rsp_data = memf(a);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // write monitor: pops expected items as handshakes occur
  initial begin
    logic [23:0] e;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && wr_valid && wr_ready) begin
        if (wr_exp.size() == 0) begin
          chk(1'b0, "R7", {wr_addr, wr_data}, 24'h0);
        end else begin
          e = wr_exp.pop_front();
          chk({wr_addr, wr_data} == e, "R7", {wr_addr, wr_data}, e);
        end
      end
      if (wr_commit) commits++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wt(5);
    // R1 reset state
    chk(sda_oe == 1'b0 && rd_valid == 1'b0 && wr_valid == 1'b0 && wr_commit == 1'b0,
        "R1", {sda_oe, rd_valid, wr_valid, wr_commit}, 4'b0000);
    rst_n = 1'b1;
    wt(5);

    // write of three bytes at 0x1234
    wr_exp.push_back({16'h1234, 8'hC1});
    wr_exp.push_back({16'h1235, 8'hC2});
    wr_exp.push_back({16'h1236, 8'hC3});
    bus_start();
    send_expect({4'hA, STRAP, 1'b0}, 1'b1, "R3");
    send_expect(8'h12, 1'b1, "R6");
    send_expect(8'h34, 1'b1, "R6");
    send_expect(8'hC1, 1'b1, "R7");
    send_expect(8'hC2, 1'b1, "R7");
    send_expect(8'hC3, 1'b1, "R7");
    bus_stop();
    wt(6);
    chk(commits == 1, "R9", commits, 1);
    chk(wr_exp.size() == 0, "R7", wr_exp.size(), 0);

    // current-address read continues after the written bytes
    bus_start();
    send_expect({4'hA, STRAP, 1'b1}, 1'b1, "R3");
    read_seq(16'h1237, 1, "R10");
    bus_stop();

    // random sequential read across the wrap point
    bus_start();
    send_expect({4'hA, STRAP, 1'b0}, 1'b1, "R12");
    send_expect(8'hFF, 1'b1, "R6");
    send_expect(8'hFE, 1'b1, "R6");
    bus_start();
    send_expect({4'hA, STRAP, 1'b1}, 1'b1, "R2");
    read_seq(16'hFFFE, 3, "R12");
    bus_stop();
    wt(4);
    chk(commits == 1, "R9", commits, 1);
    bus_start();
    send_expect({4'hA, STRAP, 1'b1}, 1'b1, "R3");
    read_seq(16'h0001, 1, "R11");
    bus_stop();

    // select mismatches
    bus_start();
    send_expect({4'hA, ~STRAP, 1'b1}, 1'b0, "R3");
    send_expect({4'hA, STRAP, 1'b0}, 1'b0, "R4");
    bus_stop();
    bus_start();
    send_expect({4'hB, STRAP, 1'b0}, 1'b0, "R3");
    bus_stop();

    // write back-pressure
    wr_ready = 1'b0;
    wr_exp.push_back({16'h0400, 8'h11});
    bus_start();
    send_expect({4'hA, STRAP, 1'b0}, 1'b1, "R3");
    send_expect(8'h04, 1'b1, "R6");
    send_expect(8'h00, 1'b1, "R6");
    send_expect(8'h11, 1'b1, "R8");
    send_expect(8'h22, 1'b0, "R8");
    bus_stop();
    wt(10);
    chk(commits == 2, "R9", commits, 2);
    chk(wr_valid == 1'b1 && wr_exp.size() == 1, "R8", {wr_valid, 8'(wr_exp.size())}, 9'h101);
    wr_ready = 1'b1;
    wt(4);
    chk(wr_exp.size() == 0, "R8", wr_exp.size(), 0);
    bus_start();
    send_expect({4'hA, STRAP, 1'b1}, 1'b1, "R3");
    read_seq(16'h0401, 1, "R8");
    bus_stop();

    // START ignored during write cycle
    write_busy = 1'b1;
    bus_start();
    send_expect({4'hA, STRAP, 1'b0}, 1'b0, "R13");
    bus_stop();
    write_busy = 1'b0;
    bus_start();
    send_expect({4'hA, STRAP, 1'b1}, 1'b1, "R13");
    read_seq(16'h0402, 1, "R11");
    bus_stop();
    wt(10);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule